// File: doc/BRIEF.md
# Oversampled Serial Frame Receiver

This block takes an asynchronous serial line that idles high and turns each frame into a parallel byte. A frame is a low start bit, the data bits with the least significant bit first, an even parity bit and a high stop bit. A free-running divider makes a clock enable at sixteen times the bit rate. A sample counter splits each bit period into sixteen ticks, and the line is read once per bit, in the middle of the bit.

The line first passes through a two-flop synchronizer. A registered copy of the synchronized line is used to find the falling edge of a start bit. At mid-start the line is checked again. If it has returned high, the event was a glitch and the controller goes back to idle. Otherwise the data bits go into a shift register. A bit counter tracks how many have arrived, and then the parity and stop bits are sampled.

A good stop bit moves the byte into the output register and pulses a valid strobe. The parity-error flag pulses at the same time if the parity check failed. A low stop bit pulses a framing-error flag instead and leaves the output register unchanged. The output can drive indicators directly or feed a downstream consumer.

Top module: `serial_frame_rx`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, data_o is 0 and valid_o, parity_err_o and frame_err_o are 0.
- R2: A well-formed frame (start 0, DATA_BITS data bits LSB first, parity, stop 1) at the configured rate makes data_o equal the transmitted byte, with valid_o high for exactly one clock cycle during the stop bit.
- R3: A low pulse on rx_i that returns high before the middle of the start bit (8 of 16 ticks) produces no valid_o, no parity_err_o and no frame_err_o, and data_o keeps its value.
- R4: The parity bit is even parity. parity_err_o pulses together with valid_o when the data bits plus the parity bit hold an odd number of ones, and stays 0 otherwise.
- R5: A stop bit sampled as 0 gives one frame_err_o pulse of one cycle, no valid_o, and data_o unchanged.
- R6: data_o changes only in a cycle where valid_o is high, and valid_o is never high in two consecutive cycles.
- R7: After a rejected glitch or a framing error, the next well-formed frame is received correctly.
- R8: Asserting rst_n low in the middle of a frame abandons that frame with no strobe. The next frame after release is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial line; idles high |
| data_o | output | DATA_BITS | Last byte accepted with a good stop bit |
| valid_o | output | 1 | One-cycle pulse when data_o loads |
| parity_err_o | output | 1 | One-cycle pulse with valid_o when parity is odd |
| frame_err_o | output | 1 | One-cycle pulse when the stop bit is low |

## Verification
The hardest condition to reach from the ports is a false start: the edge detector must fire and the controller must leave idle, and then the line must be back high when the mid-start sample is taken. This leaves no trace except the absence of output. The stimulus drives low pulses of a few ticks, then checks that no strobe appeared and data_o kept its value. A real frame follows to show that the controller returned to idle cleanly. Framing errors are reached by driving a low stop bit and then restoring the idle level so that a new edge can be found.

// File: rtl/srx_pkg.sv
package srx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_START = 3'd1,
      ST_DATA  = 3'd2,
      ST_PAR   = 3'd3,
      ST_STOP  = 3'd4
   } srx_state_t;
endpackage

// File: rtl/srx_tick_gen.sv
module srx_tick_gen #(
   parameter int DIV = 10
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   generate
      if (DIV < 1) begin : g_bad
         $error("srx_tick_gen: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_pass
         assign tick_o = 1'b1;
      end else begin : g_div
         localparam int CW = $clog2(DIV);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           cnt_q <= '0;
            else if (cnt_q == CW'(DIV - 1))       cnt_q <= '0;
            else                                  cnt_q <= cnt_q + 1'b1;
         end
         assign tick_o = (cnt_q == CW'(DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/srx_counter.sv
module srx_counter #(
   parameter int WIDTH = 4,
   parameter int MAXV  = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             en_i,
   output logic [WIDTH-1:0] cnt_o
);
   generate
      if (MAXV >= (1 << WIDTH)) begin : g_bad
         $error("srx_counter: MAXV does not fit in WIDTH");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cnt_o <= '0;
      else if (clr_i)                      cnt_o <= '0;
      else if (en_i) begin
         if (cnt_o == WIDTH'(MAXV))        cnt_o <= '0;
         else                              cnt_o <= cnt_o + 1'b1;
      end
   end

   // counter never passes its wrap value
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_o <= WIDTH'(MAXV));
endmodule

// File: rtl/srx_ctrl.sv
module srx_ctrl
   import srx_pkg::*;
#(
   parameter int DATA_BITS = 8,
   parameter int OSR       = 16,
   parameter bit PARITY_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_i,
   input  logic                 rx_i,
   input  logic                 fall_i,
   output logic [DATA_BITS-1:0] data_o,
   output logic                 valid_o,
   output logic                 perr_o,
   output logic                 ferr_o
);
   localparam int SW  = $clog2(OSR);
   localparam int BW  = $clog2(DATA_BITS + 1);
   localparam int MID = OSR / 2;

   srx_state_t           state_q, state_d;
   logic [SW-1:0]        samp_cnt;
   logic [BW-1:0]        bit_cnt;
   logic                 samp_clr, samp_en, bit_clr, bit_en;
   logic                 mid, shift_en, load;
   logic [DATA_BITS-1:0] shreg_q;
   logic                 par_q;
   srx_state_t           after_data;

   srx_counter #(.WIDTH(SW), .MAXV(OSR - 1)) u_samp (
      .clk(clk), .rst_n(rst_n), .clr_i(samp_clr), .en_i(samp_en), .cnt_o(samp_cnt));

   srx_counter #(.WIDTH(BW), .MAXV(DATA_BITS)) u_bits (
      .clk(clk), .rst_n(rst_n), .clr_i(bit_clr), .en_i(bit_en), .cnt_o(bit_cnt));

   generate
      if (PARITY_EN) begin : g_par
         assign after_data = ST_PAR;
      end else begin : g_nopar
         assign after_data = ST_STOP;
      end
   endgenerate

   assign mid      = tick_i && (samp_cnt == SW'(MID));
   assign samp_clr = (state_q == ST_IDLE);
   assign samp_en  = tick_i && (state_q != ST_IDLE);
   assign bit_clr  = (state_q == ST_IDLE);
   assign shift_en = mid && (state_q == ST_DATA);
   assign bit_en   = shift_en;
   assign load     = mid && (state_q == ST_STOP);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (fall_i) state_d = ST_START;
         ST_START: if (mid)    state_d = rx_i ? ST_IDLE : ST_DATA;
         ST_DATA:  if (mid && bit_cnt == BW'(DATA_BITS - 1)) state_d = after_data;
         ST_PAR:   if (mid)    state_d = ST_STOP;
         ST_STOP:  if (mid)    state_d = ST_IDLE;
         default:              state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         shreg_q <= '0;
         par_q   <= 1'b0;
         data_o  <= '0;
         valid_o <= 1'b0;
         perr_o  <= 1'b0;
         ferr_o  <= 1'b0;
      end else begin
         state_q <= state_d;
         valid_o <= 1'b0;
         perr_o  <= 1'b0;
         ferr_o  <= 1'b0;
         if (shift_en)                   shreg_q <= {rx_i, shreg_q[DATA_BITS-1:1]};
         if (mid && state_q == ST_PAR)   par_q   <= rx_i;
         if (load) begin
            if (rx_i) begin
               data_o  <= shreg_q;
               valid_o <= 1'b1;
               perr_o  <= PARITY_EN && ((^shreg_q) ^ par_q);
            end else begin
               ferr_o  <= 1'b1;
            end
         end
      end
   end

   // R3
   false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_START && mid && rx_i) |=> (state_q == ST_IDLE));
   // R5
   ferr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ferr_o |-> !valid_o);
   // R6
   valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);
   // R6
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(data_o) |-> valid_o);
   // R4
   perr_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      perr_o |-> valid_o);
   // R2
   bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DATA) |-> (bit_cnt < BW'(DATA_BITS)));
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx #(
   parameter int CLK_HZ    = 1_600_000,
   parameter int BAUD      = 10_000,
   parameter int OSR       = 16,
   parameter int DATA_BITS = 8,
   parameter bit PARITY_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rx_i,
   output logic [DATA_BITS-1:0] data_o,
   output logic                 valid_o,
   output logic                 parity_err_o,
   output logic                 frame_err_o
);
   localparam int DIV = CLK_HZ / (BAUD * OSR);

   generate
      if (DIV < 1) begin : g_rate_bad
         $error("serial_frame_rx: clock too slow for BAUD*OSR");
      end
      if (OSR < 4 || (OSR & (OSR - 1)) != 0) begin : g_osr_bad
         $error("serial_frame_rx: OSR must be a power of two, at least 4");
      end
      if (DATA_BITS < 1) begin : g_dw_bad
         $error("serial_frame_rx: DATA_BITS must be positive");
      end
   endgenerate

   logic sync1_q, sync2_q, prev_q, tick, fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync1_q <= 1'b1;
         sync2_q <= 1'b1;
         prev_q  <= 1'b1;
      end else begin
         sync1_q <= rx_i;
         sync2_q <= sync1_q;
         prev_q  <= sync2_q;
      end
   end

   assign fall = prev_q && !sync2_q;

   srx_tick_gen #(.DIV(DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick_o(tick));

   srx_ctrl #(.DATA_BITS(DATA_BITS), .OSR(OSR), .PARITY_EN(PARITY_EN)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .rx_i(sync2_q), .fall_i(fall),
      .data_o(data_o), .valid_o(valid_o), .perr_o(parity_err_o), .ferr_o(frame_err_o));

   // R1
   strobe_reset_chk: assert property (@(posedge clk)
      (!rst_n) |=> (!valid_o && !frame_err_o && !parity_err_o));
endmodule

// File: tb/serial_frame_rx_bench.sv
module serial_frame_rx_bench;
   localparam int CLK_PERIOD = 10;
   localparam int CLK_HZ     = 1_600_000;
   localparam int BAUD       = 10_000;
   localparam int BIT_CYC    = CLK_HZ / BAUD;
   localparam int TICK_CYC   = BIT_CYC / 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx = 1'b1;
   logic [7:0] data;
   logic       valid, perr, ferr;

   int total = 0, bad = 0;
   int n_valid = 0, n_perr = 0, n_ferr = 0, n_double = 0;
   logic [7:0] got_data = 8'h00;
   logic       last_valid = 1'b0;
   logic [7:0] held = 8'h00;
   int cyc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   serial_frame_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_serial_frame_rx (
      .clk(clk), .rst_n(rst_n), .rx_i(rx), .data_o(data), .valid_o(valid),
      .parity_err_o(perr), .frame_err_o(ferr));

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (valid) begin
         n_valid  <= n_valid + 1;
         got_data <= data;
         if (last_valid) n_double <= n_double + 1;
      end
      if (perr) n_perr <= n_perr + 1;
      if (ferr) n_ferr <= n_ferr + 1;
      last_valid <= valid;
   end

   function automatic logic even_par(input logic [7:0] d);
      return ^d;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_mon();
      @(negedge clk);
      n_valid = 0; n_perr = 0; n_ferr = 0; n_double = 0;
   endtask

   task automatic drive_bit(input logic b);
      @(negedge clk);
      rx = b;
      repeat (BIT_CYC - 1) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] d, input logic flip_par, input logic stop);
      drive_bit(1'b0);
      for (int i = 0; i < 8; i++) drive_bit(d[i]);
      drive_bit(even_par(d) ^ flip_par);
      drive_bit(stop);
      drive_bit(1'b1);
      drive_bit(1'b1);
   endtask

   task automatic frame_check(input string req, input logic [7:0] d,
                              input logic flip_par, input logic stop);
      clear_mon();
      send(d, flip_par, stop);
      if (stop) begin
         check({req, " valid count"}, n_valid, 1);
         check({req, " data"}, data, d);
         check({req, " parity flag"}, n_perr, int'(flip_par));
         check({req, " no frame err"}, n_ferr, 0);
         held = d;
      end else begin
         check({req, " frame err count"}, n_ferr, 1);
         check({req, " no valid"}, n_valid, 0);
         check({req, " data held"}, data, held);
      end
      check({req, " single-cycle valid R6"}, n_double, 0);
   endtask

   task automatic glitch(input int ticks);
      clear_mon();
      @(negedge clk);
      rx = 1'b0;
      repeat (ticks * TICK_CYC) @(negedge clk);
      rx = 1'b1;
      repeat (2 * BIT_CYC) @(negedge clk);
      check("R3 glitch no valid", n_valid, 0);
      check("R3 glitch no errors", n_ferr + n_perr, 0);
      check("R3 glitch data held", data, held);
   endtask

   initial begin
      repeat (180_000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd2718));
      repeat (5) @(negedge clk);
      check("R1 data reset", data, 0);
      check("R1 strobes reset", {valid, perr, ferr}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 first cycle after release", {data, valid, perr, ferr}, 0);
      repeat (2 * BIT_CYC) @(negedge clk);

      frame_check("R2 pattern 0xA5", 8'hA5, 1'b0, 1'b1);
      frame_check("R2 all zeros", 8'h00, 1'b0, 1'b1);
      frame_check("R2 all ones", 8'hFF, 1'b0, 1'b1);
      frame_check("R2 lsb only", 8'h01, 1'b0, 1'b1);
      frame_check("R4 bad parity", 8'h3C, 1'b1, 1'b1);
      frame_check("R4 bad parity odd byte", 8'h07, 1'b1, 1'b1);

      glitch(2);
      frame_check("R7 after glitch", 8'h5A, 1'b0, 1'b1);
      glitch(6);
      frame_check("R5 low stop", 8'hC3, 1'b0, 1'b0);
      frame_check("R7 after framing error", 8'h81, 1'b0, 1'b1);

      clear_mon();
      drive_bit(1'b0);
      drive_bit(1'b1);
      drive_bit(1'b0);
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R8 reset mid-frame no valid", n_valid + n_ferr, 0);
      check("R8 data cleared", data, 0);
      held = 8'h00;
      rx = 1'b1;
      rst_n = 1'b1;
      repeat (2 * BIT_CYC) @(negedge clk);
      frame_check("R8 frame after reset", 8'h96, 1'b0, 1'b1);

      for (int k = 0; k < 16; k++) begin
         logic [7:0] d;
         logic       fp;
         d  = 8'($urandom());
         fp = ($urandom() % 5) == 0;
         frame_check("R2/R4 random", d, fp, 1'b1);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule